// File: doc/BRIEF.md
# Register File with Auto-Modifying Pointer Pairs

This block holds the thirty-two 8-bit general registers of a small load/store processor core. Two combinational read ports and one clocked write port serve the ALU. The six highest registers are also read as three 16-bit little-endian address pointers. For a pointer-indirect access the block produces the effective address. In the same cycle it can advance the pointer by one, step it back by one, or add a displacement to it without changing the pointer.

A second arithmetic path adds a 6-bit immediate to one of the four upper register pairs, or subtracts the immediate from it. The 16-bit result is written back in one edge, and the path reports carry, zero, negative and overflow flags. The whole file also appears at the lowest data addresses. A load or store whose address falls below the register count reads or writes a register instead of data memory.

All reads are combinational, and all register updates happen at the next rising clock edge. The interface has no valid/ready handshake and never applies back-pressure. Each request pin is a one-cycle strobe that the decoder of the surrounding core asserts for the cycle of the instruction. When several writers hit the same register in one cycle, a fixed priority decides which value is stored.

Top module: `regfile_ptr_unit`

## Requirements
- R1: While reset is asserted (active low) and after it is released, every register reads 0x00 until it is written.
- R2: Read ports A and B return the addressed register combinationally. A write-port update becomes visible after the next rising edge, and a read of the same register in the write cycle returns the old value.
- R3: Pointer selection code 0 picks the pair R27:R26, code 1 picks R29:R28, and codes 2 and 3 pick R31:R30. The even register is the low byte. In mode 0 the address equals the pointer and the pointer is unchanged.
- R4: Mode 1 outputs the pointer as the address and stores pointer+1. Mode 2 outputs pointer-1 and stores pointer-1. Both wrap modulo 65536, and both bytes update in one edge.
- R5: Mode 3 outputs the pointer plus the zero-extended 6-bit displacement for codes 1 to 3 and leaves the pointer unchanged. For code 0 the displacement is ignored and the address equals the pointer.
- R6: A memory access with an address below 32 asserts mem_hit and returns the register with that index on mem_rdata. A write at such an address updates that register. At addresses of 32 and above, mem_hit and mem_rdata are 0 and no register changes.
- R7: A word operation on pair code k (k = 0..3) acts on the register pair starting at R24+2k. It adds the immediate (0 to 63) when word_sub is 0 and subtracts it when word_sub is 1. The 16-bit result is written back at the next edge.
- R8: word_flags is {V,N,Z,C} from bit 3 down to bit 0, computed on the 16-bit result. C is the carry out for an add and the borrow for a subtract. Z is set for a zero result, N is result bit 15, and V is two's-complement overflow.
- R9: When writers collide on one register, the pointer write-back wins over the word operation. The word operation wins over a memory store, and a memory store wins over the write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 5 | Write port register index |
| wr_data | input | 8 | Write port data |
| ptr_en | input | 1 | Pointer access strobe |
| ptr_sel | input | 2 | Pointer select (0 low pair, 1 middle, 2/3 top) |
| ptr_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| ptr_disp | input | 6 | Unsigned displacement |
| ptr_addr | output | 16 | Effective address |
| word_en | input | 1 | Word add/subtract strobe |
| word_pair | input | 2 | Upper pair code |
| word_sub | input | 1 | 1 subtract, 0 add |
| word_imm | input | 6 | Immediate operand |
| word_result | output | 16 | Word operation result |
| word_flags | output | 4 | {V,N,Z,C} |
| mem_en | input | 1 | Data access strobe |
| mem_we | input | 1 | Data access is a store |
| mem_addr | input | 16 | Data address |
| mem_wdata | input | 8 | Store data |
| mem_hit | output | 1 | Address falls inside the register file |
| mem_rdata | output | 8 | Load data from the register file |

## Verification
The hardest situation to reach is a single cycle in which several writers target the same register. In that case only the priority order decides what is stored. The bench reaches it by issuing a write-port write and a post-increment on the same pointer byte in one cycle. It also pairs a word operation with a pointer update on the same pair, and a memory-mapped store with a write-port write to the same index. Wrap-around of the pointer arithmetic is reached by preloading the pointers with 0xFFFF and 0x0000 through the ordinary write port.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  typedef enum logic [1:0] {
    PM_PLAIN   = 2'd0,
    PM_POSTINC = 2'd1,
    PM_PREDEC  = 2'd2,
    PM_DISP    = 2'd3
  } ptr_mode_e;

  typedef enum logic [1:0] {
    PS_LOW = 2'd0,
    PS_MID = 2'd1,
    PS_TOP = 2'd2,
    PS_ALT = 2'd3
  } ptr_sel_e;
endpackage

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int NREGS = 32,
  parameter int DW    = 8,
  localparam int IDXW = $clog2(NREGS),
  localparam int PW   = 2 * DW
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDXW-1:0]            wr_idx,
  input  logic [DW-1:0]              wr_data,
  input  logic                       mem_we,
  input  logic [IDXW-1:0]            mem_idx,
  input  logic [DW-1:0]              mem_wdata,
  input  logic                       word_we,
  input  logic [IDXW-1:0]            word_lo_idx,
  input  logic [PW-1:0]              word_val,
  input  logic                       ptr_we,
  input  logic [IDXW-1:0]            ptr_lo_idx,
  input  logic [PW-1:0]              ptr_val,
  output logic [NREGS-1:0][DW-1:0]   rf_q
);
  logic [IDXW-1:0] word_hi_idx;
  logic [IDXW-1:0] ptr_hi_idx;

  assign word_hi_idx = {word_lo_idx[IDXW-1:1], 1'b1};
  assign ptr_hi_idx  = {ptr_lo_idx[IDXW-1:1], 1'b1};

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    localparam logic [IDXW-1:0] MY_IDX = IDXW'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              rf_q[g] <= '0;
      else if (ptr_we && ptr_lo_idx == MY_IDX)   rf_q[g] <= ptr_val[DW-1:0];
      else if (ptr_we && ptr_hi_idx == MY_IDX)   rf_q[g] <= ptr_val[PW-1:DW];
      else if (word_we && word_lo_idx == MY_IDX) rf_q[g] <= word_val[DW-1:0];
      else if (word_we && word_hi_idx == MY_IDX) rf_q[g] <= word_val[PW-1:DW];
      else if (mem_we && mem_idx == MY_IDX)      rf_q[g] <= mem_wdata;
      else if (wr_en && wr_idx == MY_IDX)        rf_q[g] <= wr_data;
    end
  end

  // Checker state: remember last pointer write-back and last port write
  logic            chk_ptr_vld;
  logic [IDXW-1:0] chk_ptr_idx;
  logic [PW-1:0]   chk_ptr_val;
  logic            chk_wr_vld;
  logic [IDXW-1:0] chk_wr_idx;
  logic [DW-1:0]   chk_wr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_ptr_vld <= 1'b0;
      chk_ptr_idx <= '0;
      chk_ptr_val <= '0;
      chk_wr_vld  <= 1'b0;
      chk_wr_idx  <= '0;
      chk_wr_val  <= '0;
    end else begin
      chk_ptr_vld <= ptr_we;
      chk_ptr_idx <= ptr_lo_idx;
      chk_ptr_val <= ptr_val;
      chk_wr_vld  <= wr_en && !ptr_we && !word_we && !(mem_we && mem_idx == wr_idx);
      chk_wr_idx  <= wr_idx;
      chk_wr_val  <= wr_data;
    end
  end

  // R9: pointer write-back always lands, whatever else targeted the pair
  assert_ptr_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ptr_vld |-> (rf_q[chk_ptr_idx] == chk_ptr_val[DW-1:0] &&
                     rf_q[{chk_ptr_idx[IDXW-1:1], 1'b1}] == chk_ptr_val[PW-1:DW]));

  // R2: an uncontested port write is visible after the edge
  assert_port_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_wr_vld |-> rf_q[chk_wr_idx] == chk_wr_val);
endmodule

// File: rtl/rf_addr_gen.sv
module rf_addr_gen
  import regfile_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int DW    = 8,
  parameter int DISPW = 6,
  localparam int IDXW = $clog2(NREGS),
  localparam int PW   = 2 * DW,
  localparam int PTR_BASE = NREGS - 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ptr_en,
  input  logic [1:0]           ptr_sel,
  input  logic [1:0]           ptr_mode,
  input  logic [DISPW-1:0]     ptr_disp,
  input  logic [2:0][PW-1:0]   ptr_q,
  output logic [PW-1:0]        ea,
  output logic                 wb_en,
  output logic [IDXW-1:0]      wb_lo_idx,
  output logic [PW-1:0]        wb_val
);
  ptr_mode_e       mode;
  ptr_sel_e        sel;
  logic [1:0]      sel_eff;
  logic [PW-1:0]   cur;
  logic [PW-1:0]   disp_ext;
  logic [PW-1:0]   plus_one;
  logic [PW-1:0]   minus_one;

  assign mode     = ptr_mode_e'(ptr_mode);
  assign sel      = ptr_sel_e'(ptr_sel);
  assign sel_eff  = (sel == PS_ALT) ? 2'(PS_TOP) : ptr_sel;
  assign cur      = ptr_q[sel_eff];
  assign disp_ext = {{(PW-DISPW){1'b0}}, ptr_disp};
  assign plus_one  = cur + PW'(1);
  assign minus_one = cur - PW'(1);
  assign wb_lo_idx = IDXW'(PTR_BASE) + IDXW'({sel_eff, 1'b0});

  always_comb begin
    ea     = cur;
    wb_en  = 1'b0;
    wb_val = cur;
    unique case (mode)
      PM_PLAIN: ;
      PM_POSTINC: begin
        wb_en  = ptr_en;
        wb_val = plus_one;
      end
      PM_PREDEC: begin
        ea     = minus_one;
        wb_en  = ptr_en;
        wb_val = minus_one;
      end
      PM_DISP: begin
        if (sel != PS_LOW) ea = cur + disp_ext;
      end
      default: ;
    endcase
  end

  // R4: post-increment stores one above the address it emits
  assert_postinc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_en && mode == PM_POSTINC) |-> (wb_val == ea + PW'(1) && wb_en));

  // R4: pre-decrement emits exactly the value it stores
  assert_predec_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_en && mode == PM_PREDEC) |-> (wb_val == ea && wb_en));

  // R5: displacement mode never modifies the pointer
  assert_disp_no_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_en && mode == PM_DISP) |-> !wb_en);

  // R5: the low pair ignores the displacement
  assert_low_no_disp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_en && mode == PM_DISP && sel == PS_LOW) |-> ea == ptr_q[0]);
endmodule

// File: rtl/rf_word_alu.sv
module rf_word_alu #(
  parameter int NREGS = 32,
  parameter int DW    = 8,
  parameter int IMMW  = 6,
  localparam int IDXW = $clog2(NREGS),
  localparam int PW   = 2 * DW,
  localparam int WORD_BASE = NREGS - 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 word_en,
  input  logic [1:0]           word_pair,
  input  logic                 word_sub,
  input  logic [IMMW-1:0]      word_imm,
  input  logic [3:0][PW-1:0]   pair_q,
  output logic                 wb_en,
  output logic [IDXW-1:0]      wb_lo_idx,
  output logic [PW-1:0]        result,
  output logic [3:0]           flags
);
  logic [PW-1:0] opnd;
  logic [PW:0]   wide;
  logic [PW:0]   imm_ext;
  logic          c_flag, z_flag, n_flag, v_flag;

  assign opnd      = pair_q[word_pair];
  assign imm_ext   = {{(PW+1-IMMW){1'b0}}, word_imm};
  assign wide      = word_sub ? ({1'b0, opnd} - imm_ext) : ({1'b0, opnd} + imm_ext);
  assign result    = wide[PW-1:0];
  assign c_flag    = wide[PW];
  assign z_flag    = (result == '0);
  assign n_flag    = result[PW-1];
  assign v_flag    = word_sub ? (opnd[PW-1] & ~result[PW-1])
                              : (~opnd[PW-1] & result[PW-1]);
  assign flags     = {v_flag, n_flag, z_flag, c_flag};
  assign wb_en     = word_en;
  assign wb_lo_idx = IDXW'(WORD_BASE) + IDXW'({word_pair, 1'b0});

  // R8: without carry an add never yields a smaller value
  assert_add_nocarry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_en && !word_sub && !flags[0]) |-> result >= opnd);

  // R8: without borrow a subtract never yields a larger value
  assert_sub_noborrow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_en && word_sub && !flags[0]) |-> result <= opnd);

  // R8: zero and negative cannot both hold
  assert_zn_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_en |-> !(flags[1] && flags[2]));
endmodule

// File: rtl/regfile_ptr_unit.sv
module regfile_ptr_unit #(
  parameter int NREGS = 32,
  parameter int DW    = 8,
  parameter int DISPW = 6,
  parameter int IMMW  = 6,
  localparam int IDXW = $clog2(NREGS),
  localparam int PW   = 2 * DW,
  localparam int NPAIRS = 4,
  localparam int WORD_BASE = NREGS - 2 * NPAIRS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDXW-1:0]  rd_a_idx,
  output logic [DW-1:0]    rd_a_data,
  input  logic [IDXW-1:0]  rd_b_idx,
  output logic [DW-1:0]    rd_b_data,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             ptr_en,
  input  logic [1:0]       ptr_sel,
  input  logic [1:0]       ptr_mode,
  input  logic [DISPW-1:0] ptr_disp,
  output logic [PW-1:0]    ptr_addr,
  input  logic             word_en,
  input  logic [1:0]       word_pair,
  input  logic             word_sub,
  input  logic [IMMW-1:0]  word_imm,
  output logic [PW-1:0]    word_result,
  output logic [3:0]       word_flags,
  input  logic             mem_en,
  input  logic             mem_we,
  input  logic [PW-1:0]    mem_addr,
  input  logic [DW-1:0]    mem_wdata,
  output logic             mem_hit,
  output logic [DW-1:0]    mem_rdata
);
  logic [NREGS-1:0][DW-1:0]  rf_q;
  logic [NPAIRS-1:0][PW-1:0] pair_q;
  logic [2:0][PW-1:0]        ptr_q;
  logic                      ptr_wb_en;
  logic [IDXW-1:0]           ptr_wb_idx;
  logic [PW-1:0]             ptr_wb_val;
  logic                      word_wb_en;
  logic [IDXW-1:0]           word_wb_idx;
  logic                      mem_store;

  for (genvar k = 0; k < NPAIRS; k++) begin : g_pair
    assign pair_q[k] = {rf_q[WORD_BASE + 2*k + 1], rf_q[WORD_BASE + 2*k]};
  end
  assign ptr_q = pair_q[NPAIRS-1:1];

  assign rd_a_data = rf_q[rd_a_idx];
  assign rd_b_data = rf_q[rd_b_idx];
  assign mem_hit   = mem_en && (mem_addr < PW'(NREGS));
  assign mem_rdata = mem_hit ? rf_q[mem_addr[IDXW-1:0]] : '0;
  assign mem_store = mem_hit && mem_we;

  rf_addr_gen #(.NREGS(NREGS), .DW(DW), .DISPW(DISPW)) u_agen (
    .clk(clk), .rst_n(rst_n),
    .ptr_en(ptr_en), .ptr_sel(ptr_sel), .ptr_mode(ptr_mode), .ptr_disp(ptr_disp),
    .ptr_q(ptr_q), .ea(ptr_addr),
    .wb_en(ptr_wb_en), .wb_lo_idx(ptr_wb_idx), .wb_val(ptr_wb_val)
  );

  rf_word_alu #(.NREGS(NREGS), .DW(DW), .IMMW(IMMW)) u_walu (
    .clk(clk), .rst_n(rst_n),
    .word_en(word_en), .word_pair(word_pair), .word_sub(word_sub), .word_imm(word_imm),
    .pair_q(pair_q),
    .wb_en(word_wb_en), .wb_lo_idx(word_wb_idx), .result(word_result), .flags(word_flags)
  );

  rf_storage #(.NREGS(NREGS), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .mem_we(mem_store), .mem_idx(mem_addr[IDXW-1:0]), .mem_wdata(mem_wdata),
    .word_we(word_wb_en), .word_lo_idx(word_wb_idx), .word_val(word_result),
    .ptr_we(ptr_wb_en), .ptr_lo_idx(ptr_wb_idx), .ptr_val(ptr_wb_val),
    .rf_q(rf_q)
  );

  // R6: an address outside the file never reports a hit nor returns data
  assert_mem_hole_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_addr >= PW'(NREGS)) |-> (!mem_hit && mem_rdata == '0));

  // R6: a store outside the file with no other writer leaves the file untouched
  assert_mem_hole_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && mem_addr >= PW'(NREGS) && !wr_en && !word_en && !ptr_en)
      |=> rf_q == $past(rf_q));

  // R1: all registers clear once out of reset before any write
  assert_reset_clear_R1: assert property (@(posedge clk)
    (!rst_n) |=> (rf_q == '0));
endmodule

// File: tb/test_regfile_ptr_unit.sv
module test_regfile_ptr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [7:0]  rd_a_data, rd_b_data, wr_data = '0, mem_wdata = '0, mem_rdata;
  logic        wr_en = 1'b0, ptr_en = 1'b0, word_en = 1'b0, word_sub = 1'b0;
  logic        mem_en = 1'b0, mem_we = 1'b0, mem_hit;
  logic [1:0]  ptr_sel = '0, ptr_mode = '0, word_pair = '0;
  logic [5:0]  ptr_disp = '0, word_imm = '0;
  logic [15:0] ptr_addr, word_result, mem_addr = '0;
  logic [3:0]  word_flags;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  regfile_ptr_unit i_regfile_ptr_unit (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ptr_en(ptr_en), .ptr_sel(ptr_sel), .ptr_mode(ptr_mode), .ptr_disp(ptr_disp),
    .ptr_addr(ptr_addr),
    .word_en(word_en), .word_pair(word_pair), .word_sub(word_sub), .word_imm(word_imm),
    .word_result(word_result), .word_flags(word_flags),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_hit(mem_hit), .mem_rdata(mem_rdata)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; ptr_en = 0; word_en = 0; mem_en = 0; mem_we = 0;
    ptr_mode = 0; ptr_disp = 0; word_sub = 0; word_imm = 0;
  endtask

  task automatic put(input logic [4:0] idx, input logic [7:0] d);
    wr_en = 1; wr_idx = idx; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic get(input logic [4:0] idx, output logic [7:0] v);
    rd_b_idx = idx;
    #1 v = rd_b_data;
  endtask

  task automatic put16(input logic [4:0] lo, input logic [15:0] v);
    put(lo, v[7:0]);
    put(lo + 5'd1, v[15:8]);
  endtask

  task automatic get16(input logic [4:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    get(lo, l);
    get(lo + 5'd1, h);
    v = {h, l};
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int i = 0; i < 32; i++) begin
      get(5'(i), v);
      chk("R1 reset value", {8'h0, v}, 16'h0);
    end
  endtask

  task automatic t_rw();
    wr_en = 1; wr_idx = 5; wr_data = 8'hA5; rd_a_idx = 5;
    #1 chk("R2 old value in write cycle", {8'h0, rd_a_data}, 16'h0000);
    tick();
    wr_en = 0;
    #1 chk("R2 port A after write", {8'h0, rd_a_data}, 16'h00A5);
    put(31, 8'h3C);
    rd_a_idx = 31; rd_b_idx = 5;
    #1 chk("R2 port A R31", {8'h0, rd_a_data}, 16'h003C);
    chk("R2 port B R5", {8'h0, rd_b_data}, 16'h00A5);
  endtask

  task automatic t_plain();
    logic [15:0] v;
    put16(26, 16'h1234); put16(28, 16'h5678); put16(30, 16'h9ABC);
    ptr_en = 1; ptr_mode = 0;
    ptr_sel = 0; #1 chk("R3 low pair address", ptr_addr, 16'h1234);
    ptr_sel = 1; #1 chk("R3 middle pair address", ptr_addr, 16'h5678);
    ptr_sel = 2; #1 chk("R3 top pair address", ptr_addr, 16'h9ABC);
    ptr_sel = 3; #1 chk("R3 code 3 selects top pair", ptr_addr, 16'h9ABC);
    tick(); idle();
    get16(30, v); chk("R3 plain mode leaves pointer", v, 16'h9ABC);
  endtask

  task automatic t_incdec();
    logic [15:0] v;
    put16(26, 16'hFFFF);
    ptr_en = 1; ptr_sel = 0; ptr_mode = 1;
    #1 chk("R4 post-increment address", ptr_addr, 16'hFFFF);
    tick(); idle();
    get16(26, v); chk("R4 post-increment wrap", v, 16'h0000);
    put16(30, 16'h0000);
    ptr_en = 1; ptr_sel = 2; ptr_mode = 2;
    #1 chk("R4 pre-decrement address", ptr_addr, 16'hFFFF);
    tick(); idle();
    get16(30, v); chk("R4 pre-decrement wrap", v, 16'hFFFF);
    put16(28, 16'h01FF);
    ptr_en = 1; ptr_sel = 1; ptr_mode = 1;
    tick(); idle();
    get16(28, v); chk("R4 carry into high byte", v, 16'h0200);
  endtask

  task automatic t_disp();
    logic [15:0] v;
    put16(28, 16'h1000);
    ptr_en = 1; ptr_sel = 1; ptr_mode = 3; ptr_disp = 6'd63;
    #1 chk("R5 displacement address", ptr_addr, 16'h103F);
    tick(); idle();
    get16(28, v); chk("R5 pointer unchanged after displacement", v, 16'h1000);
    put16(26, 16'h4440);
    ptr_en = 1; ptr_sel = 0; ptr_mode = 3; ptr_disp = 6'd5;
    #1 chk("R5 low pair ignores displacement", ptr_addr, 16'h4440);
    tick(); idle();
    get16(26, v); chk("R5 low pair unchanged", v, 16'h4440);
  endtask

  task automatic t_mem();
    logic [7:0] v;
    put(7, 8'h77);
    mem_en = 1; mem_we = 0; mem_addr = 16'h0007;
    #1 chk("R6 hit below 32", {15'h0, mem_hit}, 16'h1);
    chk("R6 load from register", {8'h0, mem_rdata}, 16'h0077);
    mem_we = 1; mem_addr = 16'h001F; mem_wdata = 8'hE1;
    tick(); idle();
    get(31, v); chk("R6 store into R31", {8'h0, v}, 16'h00E1);
    put(0, 8'h11);
    mem_en = 1; mem_we = 1; mem_addr = 16'h0020; mem_wdata = 8'h99;
    #1 chk("R6 no hit at 0x20", {15'h0, mem_hit}, 16'h0);
    chk("R6 no data at 0x20", {8'h0, mem_rdata}, 16'h0000);
    tick(); idle();
    get(0, v); chk("R6 store at 0x20 leaves R0", {8'h0, v}, 16'h0011);
  endtask

  task automatic t_word();
    logic [15:0] v;
    put16(24, 16'hFFFF);
    word_en = 1; word_pair = 0; word_sub = 0; word_imm = 1;
    #1 chk("R8 flags FFFF+1", {12'h0, word_flags}, 16'h0003);
    tick(); idle();
    get16(24, v); chk("R7 add wraps to zero", v, 16'h0000);
    put16(26, 16'h7FFF);
    word_en = 1; word_pair = 1; word_sub = 0; word_imm = 1;
    #1 chk("R8 flags 7FFF+1", {12'h0, word_flags}, 16'h000C);
    tick(); idle();
    get16(26, v); chk("R7 pair code 1 result", v, 16'h8000);
    put16(28, 16'h0000);
    word_en = 1; word_pair = 2; word_sub = 1; word_imm = 1;
    #1 chk("R8 flags 0-1", {12'h0, word_flags}, 16'h0005);
    tick(); idle();
    get16(28, v); chk("R7 subtract borrow result", v, 16'hFFFF);
    put16(30, 16'h8000);
    word_en = 1; word_pair = 3; word_sub = 1; word_imm = 1;
    #1 chk("R8 flags 8000-1", {12'h0, word_flags}, 16'h0008);
    tick(); idle();
    get16(30, v); chk("R7 pair code 3 result", v, 16'h7FFF);
    put16(24, 16'h0100);
    word_en = 1; word_pair = 0; word_sub = 0; word_imm = 6'd63;
    #1 chk("R8 flags plain add", {12'h0, word_flags}, 16'h0000);
    tick(); idle();
    get16(24, v); chk("R7 add of 63", v, 16'h013F);
  endtask

  task automatic t_priority();
    logic [15:0] v;
    logic [7:0] b;
    put16(26, 16'h0010);
    ptr_en = 1; ptr_sel = 0; ptr_mode = 1;
    wr_en = 1; wr_idx = 26; wr_data = 8'hAA;
    tick(); idle();
    get16(26, v); chk("R9 pointer beats write port", v, 16'h0011);
    ptr_en = 1; ptr_sel = 0; ptr_mode = 1;
    word_en = 1; word_pair = 1; word_sub = 0; word_imm = 6'd5;
    tick(); idle();
    get16(26, v); chk("R9 pointer beats word op", v, 16'h0012);
    put16(24, 16'h0200);
    word_en = 1; word_pair = 0; word_imm = 6'd3;
    mem_en = 1; mem_we = 1; mem_addr = 16'h0018; mem_wdata = 8'h55;
    tick(); idle();
    get16(24, v); chk("R9 word op beats memory store", v, 16'h0203);
    mem_en = 1; mem_we = 1; mem_addr = 16'h0009; mem_wdata = 8'h66;
    wr_en = 1; wr_idx = 9; wr_data = 8'h33;
    tick(); idle();
    get(9, b); chk("R9 memory store beats write port", {8'h0, b}, 16'h0066);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rw();
    t_plain();
    t_incdec();
    t_disp();
    t_mem();
    t_word();
    t_priority();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule